// File: doc/BRIEF.md
# Two-Stage UART Bit-Rate Generator

This block turns a reference clock into the two timing strobes a UART transmitter and receiver need. An optional prescaler first slows the reference by a fixed factor of eight. A programmable 16-bit clock divisor then divides the selected clock into a sample strobe. A second, 8-bit divisor counts those sample strobes, and every (divisor + 1)th one also raises the bit strobe. The resulting bit rate is `f_ref / (P * CD * (BDIV + 1))`, where P is 8 with the prescaler on and 1 with it off.

The three configuration inputs are held registered inside the block. A new value is taken only at the boundary of the period it governs, so a period that is in progress always completes at its old length. A clock divisor of zero parks the generator. A bit divisor below four is raised to four. The fastest setting (prescaler off, CD = 1, BDIV = 4) gives a sample strobe on every clock and a bit strobe every fifth clock.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is high, and in the first clock after it falls, both `sample_tick` and `baud_tick` are low.
- R2: With `prescale_en` = 0 and `cd_val` = N (N >= 1), consecutive `sample_tick` pulses are exactly N clocks apart.
- R3: With `prescale_en` = 1, consecutive `sample_tick` pulses are exactly 8*N clocks apart.
- R4: Consecutive `baud_tick` pulses are exactly P*N*(B+1) clocks apart, where P is 8 or 1 per `prescale_en` and B is the effective bit divisor.
- R5: `baud_tick` is high only in a cycle in which `sample_tick` is also high, once every (B+1) sample pulses.
- R6: A `bdiv_val` of 0, 1, 2 or 3 gives the same timing as a `bdiv_val` of 4 (B = max(`bdiv_val`, 4)).
- R7: A `cd_val` of 0 stops both strobes once the running sample period has ended. A later nonzero value restarts them with the new period.
- R8: A change to `cd_val`, `bdiv_val` or `prescale_en` in mid-period does not alter the length of the period in progress. The new value governs from the next period on.
- R9: With prescaler off, `cd_val` = 1 and `bdiv_val` = 4, `sample_tick` is high on every clock and `baud_tick` pulses every 5 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| prescale_en | input | 1 | 1 selects reference/8, 0 selects the reference clock |
| cd_val | input | 16 | Clock divisor, 0 parks the generator |
| bdiv_val | input | 8 | Bit divisor, sample strobes per bit minus one, floor 4 |
| sample_tick | output | 1 | One-clock strobe per clock-divisor period |
| baud_tick | output | 1 | One-clock strobe per bit period |

## Verification
A counter that drifts out of its range shows up as a strobe interval that is wrong on the very next period. An invalid stuck state shows up as strobes that stop entirely. A divisor latched at the wrong moment shows up as a single interval of mixed length right after a mid-period write, so the bench measures the interval that spans each write as well as the one after it. A baud divider that slips against the sample divider shows up as a bit strobe without a sample strobe in the same cycle, and that is visible as soon as the first bit period ends.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned CD_WIDTH_DEF   = 16;
  localparam int unsigned BD_WIDTH_DEF   = 8;
  localparam int unsigned PRESCALE_DEF   = 8;
  localparam int unsigned BD_FLOOR_DEF   = 4;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_DIV = baud_gen_pkg::PRESCALE_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_in,
  input  logic reload,
  output logic pre_en
);
  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic          sel_q;
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          sel_q <= 1'b0;
          pcnt  <= '0;
        end else if (reload) begin
          sel_q <= sel_in;
          pcnt  <= '0;
        end else if (sel_q) begin
          pcnt  <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
        end
      end

      assign pre_en = !sel_q || (pcnt == LAST);

      // R8: the prescale choice only moves at a divisor boundary
      assert_sel_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(sel_q));
      // R3: a divided enable never repeats on back-to-back clocks
      assert_pre_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_q && pre_en && !reload) |=> !pre_en);
    end else begin : g_nodiv
      assign pre_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/baud_cd_div.sv
module baud_cd_div #(
  parameter int unsigned CD_W = baud_gen_pkg::CD_WIDTH_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [CD_W-1:0] cd_in,
  output logic            idle,
  output logic            wrap,
  output logic            tick_q
);
  logic [CD_W-1:0] cd_q;
  logic [CD_W-1:0] cnt;

  assign idle = (cd_q == '0);
  assign wrap = !idle && en && (cnt == CD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_q   <= '0;
      cnt    <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (idle || wrap) begin
        cd_q <= cd_in;
        cnt  <= cd_in;
      end else if (en) begin
        cnt  <= cnt - 1'b1;
      end
    end
  end

  // R2: the down counter stays within the latched period while running
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (cnt != '0) && (cnt <= cd_q));
  // R8: the latched divisor is held for the whole period
  assert_cd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(idle || wrap) |=> $stable(cd_q));
  // R7: a parked divider emits nothing on the following clock
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    idle |=> !tick_q);
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned BD_W   = baud_gen_pkg::BD_WIDTH_DEF,
  parameter int unsigned BD_MIN = baud_gen_pkg::BD_FLOOR_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle,
  input  logic            step,
  input  logic [BD_W-1:0] bd_in,
  output logic            tick_q
);
  localparam int unsigned CW = BD_W + 1;
  localparam logic [BD_W-1:0] FLOOR = BD_W'(BD_MIN);

  logic [BD_W-1:0] bd_q;
  logic [BD_W-1:0] bd_eff;
  logic [CW-1:0]   bcnt;
  logic [CW-1:0]   span;

  assign bd_eff = (bd_in < FLOOR) ? FLOOR : bd_in;
  assign span   = {1'b0, bd_eff} + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bd_q   <= FLOOR;
      bcnt   <= {1'b0, FLOOR} + CW'(1);
      tick_q <= 1'b0;
    end else if (idle) begin
      bd_q   <= bd_eff;
      bcnt   <= span;
      tick_q <= 1'b0;
    end else if (step) begin
      tick_q <= (bcnt == CW'(1));
      if (bcnt == CW'(1)) begin
        bd_q <= bd_eff;
        bcnt <= span;
      end else begin
        bcnt <= bcnt - 1'b1;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  // R6: the latched bit divisor never drops under the floor
  assert_bdiv_floor_R6: assert property (@(posedge clk) disable iff (rst)
    bd_q >= FLOOR);
  // R4: the sample count stays within one bit period
  assert_bcnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    (bcnt != '0) && (bcnt <= {1'b0, bd_q} + CW'(1)));
  // R8: the bit divisor changes only at a bit boundary or while parked
  assert_bd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(idle || (step && bcnt == CW'(1))) |=> $stable(bd_q));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned CD_W    = baud_gen_pkg::CD_WIDTH_DEF,
  parameter int unsigned BD_W    = baud_gen_pkg::BD_WIDTH_DEF,
  parameter int unsigned PRE_DIV = baud_gen_pkg::PRESCALE_DEF,
  parameter int unsigned BD_MIN  = baud_gen_pkg::BD_FLOOR_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prescale_en,
  input  logic [CD_W-1:0] cd_val,
  input  logic [BD_W-1:0] bdiv_val,
  output logic            sample_tick,
  output logic            baud_tick
);
  logic pre_en;
  logic cd_idle;
  logic cd_wrap;

  baud_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .sel_in (prescale_en),
    .reload (cd_idle || cd_wrap),
    .pre_en (pre_en)
  );

  baud_cd_div #(.CD_W(CD_W)) u_cd (
    .clk    (clk),
    .rst    (rst),
    .en     (pre_en),
    .cd_in  (cd_val),
    .idle   (cd_idle),
    .wrap   (cd_wrap),
    .tick_q (sample_tick)
  );

  baud_bit_div #(.BD_W(BD_W), .BD_MIN(BD_MIN)) u_bit (
    .clk    (clk),
    .rst    (rst),
    .idle   (cd_idle),
    .step   (cd_wrap),
    .bd_in  (bdiv_val),
    .tick_q (baud_tick)
  );

  // R5: a bit strobe always lands on a sample strobe
  assert_baud_on_sample_R5: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> sample_tick);
  // R1: strobes stay low in the first clock after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !sample_tick && !baud_tick);
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prescale_en = 1'b0;
  logic [15:0] cd_val = 16'd0;
  logic [7:0]  bdiv_val = 8'd4;
  logic        sample_tick;
  logic        baud_tick;

  int    checks = 0;
  int    errors = 0;
  longint cyc = 0;
  bit    done = 1'b0;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst(rst), .prescale_en(prescale_en),
    .cd_val(cd_val), .bdiv_val(bdiv_val),
    .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R5: every bit strobe must coincide with a sample strobe
  always @(negedge clk) begin
    if (!rst && baud_tick) chk(sample_tick, "R5", sample_tick, 1);
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sample_tick && !baud_tick, "R1", {sample_tick, baud_tick}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sample_tick && !baud_tick, "R1", {sample_tick, baud_tick}, 0);
  endtask

  task automatic wait_s(output longint t);
    t = -1;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (sample_tick) begin t = cyc; break; end
    end
  endtask

  task automatic wait_b(output longint t);
    t = -1;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (baud_tick) begin t = cyc; break; end
    end
  endtask

  task automatic run_combo(input int cd, input int bd, input bit sel);
    longint t0, t1, t2, es, eb;
    int beff;
    string rq;
    beff = (bd < 4) ? 4 : bd;
    es = longint'(cd) * (sel ? 8 : 1);
    eb = es * (beff + 1);
    cd_val = 16'(cd); bdiv_val = 8'(bd); prescale_en = sel;
    do_reset();
    rq = (bd < 4) ? "R6" : "R4";
    wait_b(t0); wait_b(t1); wait_b(t2);
    chk(t0 >= 0 && t1 - t0 == eb, rq, t1 - t0, eb);
    chk(t0 >= 0 && t2 - t1 == eb, rq, t2 - t1, eb);
    rq = sel ? "R3" : "R2";
    wait_s(t0); wait_s(t1);
    chk(t0 >= 0 && t1 - t0 == es, rq, t1 - t0, es);
  endtask

  initial begin
    longint a, b, c;
    int cnt;
    int cds[4] = '{1, 2, 3, 5};
    int bds[5] = '{0, 2, 4, 5, 6};

    // R2 R3 R4 R6: sweep over divisors and prescale
    foreach (cds[i]) foreach (bds[j]) for (int s = 0; s < 2; s++)
      run_combo(cds[i], bds[j], s[0]);
    run_combo(300, 4, 1'b1);

    // R9: fastest setting
    cd_val = 16'd1; bdiv_val = 8'd4; prescale_en = 1'b0;
    do_reset();
    wait_s(a);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sample_tick) cnt++; end
    chk(cnt == 20, "R9", cnt, 20);
    wait_b(a); wait_b(b);
    chk(b - a == 5, "R9", b - a, 5);

    // R7: parked generator from reset, then restart
    cd_val = 16'd0;
    do_reset();
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); if (sample_tick || baud_tick) cnt++; end
    chk(cnt == 0, "R7", cnt, 0);
    cd_val = 16'd3;
    wait_s(a); wait_s(b);
    chk(a >= 0 && b - a == 3, "R7", b - a, 3);
    // R7: parking while running
    cd_val = 16'd0;
    repeat (20) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 500; i++) begin @(negedge clk); if (sample_tick || baud_tick) cnt++; end
    chk(cnt == 0, "R7", cnt, 0);

    // R8: clock divisor change in mid-period
    cd_val = 16'd4; bdiv_val = 8'd4; prescale_en = 1'b0;
    do_reset();
    wait_s(a);
    repeat (2) @(negedge clk);
    cd_val = 16'd6;
    wait_s(b); wait_s(c);
    chk(b - a == 4, "R8", b - a, 4);
    chk(c - b == 6, "R8", c - b, 6);

    // R8: prescale change in mid-period
    cd_val = 16'd3; prescale_en = 1'b0;
    do_reset();
    wait_s(a);
    @(negedge clk);
    prescale_en = 1'b1;
    wait_s(b); wait_s(c);
    chk(b - a == 3, "R8", b - a, 3);
    chk(c - b == 24, "R8", c - b, 24);

    // R8: bit divisor change in mid-period
    cd_val = 16'd2; bdiv_val = 8'd4; prescale_en = 1'b0;
    do_reset();
    wait_b(a);
    repeat (3) @(negedge clk);
    bdiv_val = 8'd9;
    wait_b(b); wait_b(c);
    chk(b - a == 10, "R8", b - a, 10);
    chk(c - b == 20, "R8", c - b, 20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule